// File: doc/BRIEF.md
# ADC Scan and Trigger Sequencer

This block is the digital controller in front of a four-channel, 12-bit analog-to-digital converter. It decides which channel is converted next and starts each conversion through a start/channel/done/data handshake. It also keeps the latest result of every channel. Channel 0 has an extra slot, so the two most recent conversions of that channel are both available. The converter is started either by a software start strobe or by rising edges on a timer trigger pin or an external trigger pin. Both pins are asynchronous and are synchronised inside the block.

Four modes are available:

- Single mode converts one chosen channel once.
- One-pass scan converts each enabled channel once, in ascending order.
- Continuous scan keeps repeating the pass until the global enable is removed.
- Two-group scan splits the enabled channels into group A and group B. Each group has its own start source, its own done pulse and its own missed-trigger pulse.

A self-diagnostic code is passed to the converter with every start, so the converter can sample an internal reference instead of the pin. Stored results can be read back at full precision, or right-shifted to 10-bit or 8-bit precision.

Top module: `adc_scan_seq`

## Requirements
- R1: With `cfg_mode`=0 (single), one accepted start converts only channel `cfg_single_ch`, regardless of `cfg_scan_en`. Completion is marked by exactly one `done_a` pulse of one cycle.
- R2: With `cfg_mode`=1 (one-pass scan), one accepted start converts every channel whose bit is set in `cfg_scan_en`, once each, in ascending channel order. It then raises one `done_a` pulse and stops.
- R3: With `cfg_mode`=2 (continuous), the enabled channels are converted in ascending order, over and over, with no `done_a` pulse. When `enable` goes low, the conversion in flight finishes and no further conversion starts.
- R4: With `cfg_mode`=3 (two-group), channels with their `cfg_grp_b` bit set form group B and the rest form group A, both limited to `cfg_scan_en`. Group A starts from `cfg_src_a` and group B starts from `cfg_src_b`. Group A ends with `done_a` and group B ends with `done_b`.
- R5: If both groups are started in the same cycle, all of group A is converted before group B. `done_a` is raised before `done_b`.
- R6: Start-source codes are: 0 = software strobe (`sw_start_a` / `sw_start_b`), 1 = rising edge of `tmr_trig`, 2 = rising edge of `ext_trig`, 3 = no source. A software strobe gives `conv_start` 3 clock edges after the strobe edge. A pin edge gives `conv_start` 5 edges after the pin rises, because of two synchroniser flops. A held-high pin starts only once, and sources not selected are ignored.
- R7: A start that arrives while its group is pending or converting is ignored. It raises a one-cycle `miss_a` or `miss_b` pulse and adds no conversion.
- R8: `rd_data` returns the stored result selected by `rd_sel`. It is shifted right by 0 bits when `cfg_shift` is 0 or 3, by 2 bits when `cfg_shift` is 1, and by 4 bits when `cfg_shift` is 2.
- R9: `rd_sel` 0..3 returns the latest result of that channel. `rd_sel`=4 returns the result of channel 0 from before its latest conversion.
- R10: Each `conv_start` carries `conv_ch` and `conv_ref`, which is a copy of `cfg_diag`: 0 = input pin, 1 = low reference, 2 = half high reference, 3 = high reference. Both stay stable until `conv_done`.
- R11: `conv_start` is a one-cycle pulse. No new start is issued while a conversion is outstanding.
- R12: After reset, all pulses and `conv_start` are low and every result slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global run enable; low ignores starts and stops scans |
| cfg_mode | input | 2 | 0 single, 1 one-pass, 2 continuous, 3 two-group |
| cfg_single_ch | input | 2 | Channel for single mode |
| cfg_scan_en | input | 4 | Per-channel scan enable |
| cfg_grp_b | input | 4 | Per-channel group B membership (two-group mode) |
| cfg_src_a | input | 2 | Start source of group A / whole scan |
| cfg_src_b | input | 2 | Start source of group B |
| cfg_diag | input | 2 | Self-diagnostic code forwarded with each start |
| cfg_shift | input | 2 | Read-out precision select |
| sw_start_a | input | 1 | Software start strobe, group A |
| sw_start_b | input | 1 | Software start strobe, group B |
| tmr_trig | input | 1 | Asynchronous timer trigger |
| ext_trig | input | 1 | Asynchronous external trigger |
| rd_sel | input | 3 | Result slot select |
| rd_data | output | 12 | Selected result, shifted |
| conv_start | output | 1 | Converter start pulse |
| conv_ch | output | 2 | Channel to convert |
| conv_ref | output | 2 | Diagnostic code for the converter |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 12 | Converter result |
| done_a | output | 1 | Group A / scan completion pulse |
| done_b | output | 1 | Group B completion pulse |
| miss_a | output | 1 | Group A start dropped while busy |
| miss_b | output | 1 | Group B start dropped while busy |

## Verification
The sequencer is exercised with several enable patterns:

- A sparse mask in one-pass scan shows that skipped channels are never converted and that the order is ascending.
- A single-mode run with a mismatched scan mask shows that single mode ignores the mask.
- A two-channel continuous run shows that the pass repeats, no done pulse is raised, and the scan stops cleanly on disable.

Two-group runs are started from one group alone, from software for group B, and from both pins rising together. These separate the group split, the per-group sources and the A-before-B ordering. Repeated starts during a busy scan, held trigger pins and unselected sources show that only fresh edges from the chosen source are taken.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_ONCE   = 2'd1,
        MODE_CONT   = 2'd2,
        MODE_GROUP  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SRC_SW  = 2'd0,
        SRC_TMR = 2'd1,
        SRC_EXT = 2'd2,
        SRC_OFF = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_WAIT = 2'd2
    } st_e;

    function automatic logic src_hit(input logic [1:0] src, input logic sw,
                                     input logic tmr, input logic ext);
        case (src_e'(src))
            SRC_SW:  return sw;
            SRC_TMR: return tmr;
            SRC_EXT: return ext;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/adcs_edge_sync.sv
module adcs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-1:0], pin};

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adcs_first_set.sv
module adcs_first_set #(
    parameter int N = 4,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/adcs_result_bank.sv
module adcs_result_bank #(
    parameter int NCH    = 4,
    parameter int DW     = 12,
    parameter int CHW    = 2,
    parameter int SH_MID = 2,
    parameter int SH_LOW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [DW-1:0]  wr_data,
    input  logic [CHW:0]   rd_sel,
    input  logic [1:0]     rd_shift,
    output logic [DW-1:0]  rd_data
);
    localparam int NSLOT = NCH + 1;
    localparam int OLD   = NCH;

    logic [DW-1:0] slot_d [NSLOT];
    logic [DW-1:0] slot_q [NSLOT];
    logic [DW-1:0] raw;

    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            if (wr_ch == '0) slot_d[OLD] = slot_q[0];
            slot_d[int'(wr_ch)] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (int'(rd_sel) == i) raw = slot_q[i];
        end
        case (rd_shift)
            2'd1:    rd_data = raw >> SH_MID;
            2'd2:    rd_data = raw >> SH_LOW;
            default: rd_data = raw;
        endcase
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adcs_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 12,
    parameter int SYNC   = 2,
    parameter int SH_MID = 2,
    parameter int SH_LOW = 4,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [1:0]     cfg_mode,
    input  logic [CHW-1:0] cfg_single_ch,
    input  logic [NCH-1:0] cfg_scan_en,
    input  logic [NCH-1:0] cfg_grp_b,
    input  logic [1:0]     cfg_src_a,
    input  logic [1:0]     cfg_src_b,
    input  logic [1:0]     cfg_diag,
    input  logic [1:0]     cfg_shift,
    input  logic           sw_start_a,
    input  logic           sw_start_b,
    input  logic           tmr_trig,
    input  logic           ext_trig,
    input  logic [CHW:0]   rd_sel,
    output logic [DW-1:0]  rd_data,
    output logic           conv_start,
    output logic [CHW-1:0] conv_ch,
    output logic [1:0]     conv_ref,
    input  logic           conv_done,
    input  logic [DW-1:0]  conv_data,
    output logic           done_a,
    output logic           done_b,
    output logic           miss_a,
    output logic           miss_b
);
    localparam int NPIN = 2;

    typedef struct packed {
        st_e            st;
        logic           grp_b;
        logic           pend_a;
        logic           pend_b;
        logic [NCH-1:0] rem;
        logic [CHW-1:0] ch;
        logic [1:0]     rsel;
        logic           start;
        logic           done_a;
        logic           done_b;
        logic           miss_a;
        logic           miss_b;
    } seq_t;

    seq_t q, d;

    // trigger pin synchronisers: index 0 timer, index 1 external
    logic [NPIN-1:0] pin_raw, pin_rise;
    assign pin_raw = {ext_trig, tmr_trig};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        adcs_edge_sync #(.STAGES(SYNC)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_raw[g]),
            .rise (pin_rise[g])
        );
    end

    logic [NCH-1:0] mask_a, mask_b, one_ch;
    logic [CHW-1:0] pick_idx;
    logic           pick_any;
    logic           hit_a, hit_b, busy_a, busy_b;
    mode_e          mode;

    adcs_first_set #(.N(NCH), .W(CHW)) u_pick (
        .vec(q.rem),
        .idx(pick_idx),
        .any(pick_any)
    );

    always_comb begin
        mode   = mode_e'(cfg_mode);
        one_ch = NCH'(1) << cfg_single_ch;
        case (mode)
            MODE_SINGLE: mask_a = one_ch;
            MODE_GROUP:  mask_a = cfg_scan_en & ~cfg_grp_b;
            default:     mask_a = cfg_scan_en;
        endcase
        mask_b = cfg_scan_en & cfg_grp_b;

        hit_a  = enable & src_hit(cfg_src_a, sw_start_a, pin_rise[0], pin_rise[1]);
        hit_b  = enable & (mode == MODE_GROUP)
               & src_hit(cfg_src_b, sw_start_b, pin_rise[0], pin_rise[1]);
        busy_a = q.pend_a | ((q.st != ST_IDLE) & ~q.grp_b);
        busy_b = q.pend_b | ((q.st != ST_IDLE) &  q.grp_b);

        d        = q;
        d.start  = 1'b0;
        d.done_a = 1'b0;
        d.done_b = 1'b0;
        d.miss_a = 1'b0;
        d.miss_b = 1'b0;

        if (hit_a) begin
            if (busy_a) d.miss_a = 1'b1;
            else        d.pend_a = 1'b1;
        end
        if (hit_b) begin
            if (busy_b) d.miss_b = 1'b1;
            else        d.pend_b = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (enable && q.pend_a) begin
                    d.pend_a = 1'b0;
                    d.grp_b  = 1'b0;
                    d.rem    = mask_a;
                    d.st     = ST_PICK;
                end else if (enable && q.pend_b) begin
                    d.pend_b = 1'b0;
                    d.grp_b  = 1'b1;
                    d.rem    = mask_b;
                    d.st     = ST_PICK;
                end
            end
            ST_PICK: begin
                if (!enable) begin
                    d.st = ST_IDLE;
                end else if (!pick_any) begin
                    if (mode == MODE_CONT && !q.grp_b) begin
                        d.rem = mask_a;
                    end else begin
                        d.done_a = ~q.grp_b;
                        d.done_b = q.grp_b;
                        d.st     = ST_IDLE;
                    end
                end else begin
                    d.ch    = pick_idx;
                    d.rem   = q.rem & ~(NCH'(1) << pick_idx);
                    d.rsel  = cfg_diag;
                    d.start = 1'b1;
                    d.st    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (conv_done) d.st = ST_PICK;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    adcs_result_bank #(
        .NCH(NCH), .DW(DW), .CHW(CHW), .SH_MID(SH_MID), .SH_LOW(SH_LOW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   ((q.st == ST_WAIT) && conv_done),
        .wr_ch   (q.ch),
        .wr_data (conv_data),
        .rd_sel  (rd_sel),
        .rd_shift(cfg_shift),
        .rd_data (rd_data)
    );

    assign conv_start = q.start;
    assign conv_ch    = q.ch;
    assign conv_ref   = q.rsel;
    assign done_a     = q.done_a;
    assign done_b     = q.done_b;
    assign miss_a     = q.miss_a;
    assign miss_b     = q.miss_b;
endmodule

// File: rtl/adcs_checker.sv
module adcs_checker #(
    parameter int NCH    = 4,
    parameter int DW     = 12,
    parameter int SH_LOW = 4,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     cfg_mode,
    input logic [1:0]     cfg_shift,
    input logic [DW-1:0]  rd_data,
    input logic           conv_start,
    input logic [CHW-1:0] conv_ch,
    input logic [1:0]     conv_ref,
    input logic           conv_done,
    input logic           done_a,
    input logic           done_b
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          busy_q <= 1'b0;
        else if (conv_start) busy_q <= 1'b1;
        else if (conv_done)  busy_q <= 1'b0;
    end

    p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !conv_done) |-> !conv_start);

    p_ch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ($stable(conv_ch) && $stable(conv_ref)));

    p_done_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_a && done_b));

    p_cont_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && $past(cfg_mode) == 2'd2) |-> !done_a);

    p_group_b_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_b |-> $past(cfg_mode) == 2'd3);

    p_shift_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_shift == 2'd2) |-> ((rd_data >> (DW - SH_LOW)) == '0));
endmodule

bind adc_scan_seq adcs_checker #(.NCH(NCH), .DW(DW), .SH_LOW(SH_LOW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_shift (cfg_shift),
    .rd_data   (rd_data),
    .conv_start(conv_start),
    .conv_ch   (conv_ch),
    .conv_ref  (conv_ref),
    .conv_done (conv_done),
    .done_a    (done_a),
    .done_b    (done_b)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        enable = 1'b1;
    logic [1:0]  cfg_mode = 2'd0, cfg_src_a = 2'd0, cfg_src_b = 2'd3;
    logic [1:0]  cfg_diag = 2'd0, cfg_shift = 2'd0, cfg_single_ch = 2'd0;
    logic [3:0]  cfg_scan_en = 4'd0, cfg_grp_b = 4'd0;
    logic        sw_start_a = 1'b0, sw_start_b = 1'b0, tmr_trig = 1'b0, ext_trig = 1'b0;
    logic [2:0]  rd_sel = 3'd0;
    logic [11:0] rd_data;
    logic        conv_start, conv_done = 1'b0;
    logic [1:0]  conv_ch, conv_ref;
    logic [11:0] conv_data = 12'd0;
    logic        done_a, done_b, miss_a, miss_b;

    adc_scan_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mode(cfg_mode),
        .cfg_single_ch(cfg_single_ch), .cfg_scan_en(cfg_scan_en), .cfg_grp_b(cfg_grp_b),
        .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b), .cfg_diag(cfg_diag),
        .cfg_shift(cfg_shift), .sw_start_a(sw_start_a), .sw_start_b(sw_start_b),
        .tmr_trig(tmr_trig), .ext_trig(ext_trig), .rd_sel(rd_sel), .rd_data(rd_data),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_ref(conv_ref),
        .conv_done(conv_done), .conv_data(conv_data), .done_a(done_a), .done_b(done_b),
        .miss_a(miss_a), .miss_b(miss_b)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model state
    int exp_q[$];
    int exp_ref = 0;
    int starts = 0, dones_a = 0, dones_b = 0, misses_a = 0, misses_b = 0;
    int first_start_cyc = -1, done_a_cyc = -1, done_b_cyc = -1;
    int outst = 0, stub_cnt = 0, stub_ch = 0, stub_ref = 0, seqn = 0;
    int mdl_res[5] = '{0, 0, 0, 0, 0};

    function automatic int conv_value(input int ch, input int rf, input int n);
        case (rf)
            1: return 0;
            2: return 12'h800;
            3: return 12'hFFF;
            default: return (ch * 977 + n * 53 + 5) % 4096;
        endcase
    endfunction

    // converter stub and per-clock comparison against the model
    always @(negedge clk) begin
        if (conv_done) conv_done = 1'b0;
        if (rst_n) begin
            if (conv_start) begin
                starts++;
                if (first_start_cyc < 0) first_start_cyc = cyc;
                chk(outst == 0, "R11", "start while outstanding", outst, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected conversion of channel", int'(conv_ch), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(conv_ch) == e, "R2", "channel order", int'(conv_ch), e);
                end
                chk(int'(conv_ref) == exp_ref, "R10", "diag code", int'(conv_ref), exp_ref);
                outst = 1;
                stub_ch = int'(conv_ch);
                stub_ref = int'(conv_ref);
                stub_cnt = LAT;
            end else if (stub_cnt > 0) begin
                stub_cnt--;
                if (stub_cnt == 0) begin
                    int v;
                    v = conv_value(stub_ch, stub_ref, seqn);
                    seqn++;
                    conv_data = 12'(v);
                    conv_done = 1'b1;
                    if (stub_ch == 0) mdl_res[4] = mdl_res[0];
                    mdl_res[stub_ch] = v;
                    outst = 0;
                end
            end
            if (done_a) begin dones_a++; done_a_cyc = cyc; end
            if (done_b) begin dones_b++; done_b_cyc = cyc; end
            if (miss_a) misses_a++;
            if (miss_b) misses_b++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        starts = 0; dones_a = 0; dones_b = 0; misses_a = 0; misses_b = 0;
        first_start_cyc = -1; done_a_cyc = -1; done_b_cyc = -1;
        exp_q.delete();
    endtask

    task automatic pulse_sw_a(output int at);
        @(negedge clk);
        sw_start_a = 1'b1;
        at = cyc;
        @(negedge clk);
        sw_start_a = 1'b0;
    endtask

    task automatic read_chk(input int sel, input int sh, input int exp, input string req);
        @(negedge clk);
        rd_sel = 3'(sel);
        cfg_shift = 2'(sh);
        #1;
        chk(int'(rd_data) == exp, req, $sformatf("rd_data sel=%0d shift=%0d", sel, sh),
            int'(rd_data), exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            chk(1'b0, "WD", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int at;
        // R12 reset state
        tick(3);
        chk(!conv_start && !done_a && !done_b && !miss_a && !miss_b, "R12",
            "outputs low in reset", int'(conv_start), 0);
        rst_n = 1'b1;
        for (int s = 0; s < 5; s++) read_chk(s, 0, 0, "R12");

        // R1 single mode ignores scan enables; software latency (R6)
        clear_counts();
        cfg_mode = 2'd0; cfg_single_ch = 2'd2; cfg_scan_en = 4'b0001; cfg_src_a = 2'd0;
        exp_q = '{2};
        pulse_sw_a(at);
        tick(30);
        chk(first_start_cyc - at == 3, "R6", "software start latency", first_start_cyc - at, 3);
        chk(starts == 1, "R1", "single conversions", starts, 1);
        chk(dones_a == 1, "R1", "single done pulses", dones_a, 1);
        read_chk(2, 0, mdl_res[2], "R1");

        // R2 one-pass scan over a sparse mask, run twice for R9
        for (int rep = 0; rep < 2; rep++) begin
            clear_counts();
            cfg_mode = 2'd1; cfg_scan_en = 4'b1011;
            exp_q = '{0, 1, 3};
            pulse_sw_a(at);
            tick(40);
            chk(starts == 3, "R2", "one-pass conversions", starts, 3);
            chk(dones_a == 1 && dones_b == 0, "R2", "one-pass done pulses", dones_a, 1);
            chk(exp_q.size() == 0, "R2", "channels left unconverted", exp_q.size(), 0);
        end
        read_chk(0, 0, mdl_res[0], "R9");
        read_chk(4, 0, mdl_res[4], "R9");
        read_chk(1, 0, mdl_res[1], "R2");
        read_chk(3, 0, mdl_res[3], "R2");

        // R8 precision select
        read_chk(3, 1, mdl_res[3] >> 2, "R8");
        read_chk(3, 2, mdl_res[3] >> 4, "R8");
        read_chk(3, 3, mdl_res[3], "R8");
        read_chk(1, 2, mdl_res[1] >> 4, "R8");

        // R7 start during a busy scan
        clear_counts();
        cfg_scan_en = 4'b1111;
        exp_q = '{0, 1, 2, 3};
        pulse_sw_a(at);
        tick(3);
        pulse_sw_a(at);
        tick(50);
        chk(misses_a == 1, "R7", "miss pulses", misses_a, 1);
        chk(starts == 4, "R7", "conversions after busy start", starts, 4);
        chk(dones_a == 1, "R7", "done pulses after busy start", dones_a, 1);

        // R6 timer source: software ignored, held level starts once
        clear_counts();
        cfg_src_a = 2'd1;
        pulse_sw_a(at);
        tick(20);
        chk(starts == 0, "R6", "software start with timer source", starts, 0);
        cfg_mode = 2'd0; cfg_single_ch = 2'd1;
        exp_q = '{1};
        @(negedge clk); tmr_trig = 1'b1; at = cyc;
        tick(30);
        chk(first_start_cyc - at == 5, "R6", "timer start latency", first_start_cyc - at, 5);
        chk(starts == 1, "R6", "held timer level conversions", starts, 1);
        tmr_trig = 1'b0;
        tick(5);

        // R6 external source
        clear_counts();
        cfg_src_a = 2'd2; cfg_single_ch = 2'd3;
        exp_q = '{3};
        @(negedge clk); ext_trig = 1'b1; at = cyc;
        tick(30);
        ext_trig = 1'b0;
        chk(first_start_cyc - at == 5, "R6", "external start latency", first_start_cyc - at, 5);
        chk(starts == 1, "R6", "external conversions", starts, 1);
        tick(5);

        // R10 diagnostic references on channel 0
        clear_counts();
        cfg_src_a = 2'd0; cfg_single_ch = 2'd0; cfg_diag = 2'd3; exp_ref = 3;
        exp_q = '{0};
        pulse_sw_a(at);
        tick(30);
        read_chk(0, 0, 12'hFFF, "R10");
        cfg_diag = 2'd2; exp_ref = 2;
        exp_q = '{0};
        pulse_sw_a(at);
        tick(30);
        read_chk(0, 0, 12'h800, "R10");
        read_chk(4, 0, 12'hFFF, "R9");
        cfg_diag = 2'd0; exp_ref = 0;

        // R3 continuous scan, stopped by enable
        clear_counts();
        cfg_mode = 2'd2; cfg_scan_en = 4'b0110;
        for (int k = 0; k < 20; k++) begin exp_q.push_back(1); exp_q.push_back(2); end
        pulse_sw_a(at);
        tick(4);
        pulse_sw_a(at);
        for (int w = 0; w < 2000 && starts < 6; w++) @(negedge clk);
        enable = 1'b0;
        tick(30);
        chk(starts == 6, "R3", "conversions after disable", starts, 6);
        chk(dones_a == 0, "R3", "continuous done pulses", dones_a, 0);
        chk(misses_a == 1, "R7", "miss during continuous scan", misses_a, 1);
        exp_q.delete();
        enable = 1'b1;
        tick(20);
        chk(starts == 6, "R3", "no restart after re-enable", starts, 6);

        // R4 two-group: group B alone from external pin
        clear_counts();
        cfg_mode = 2'd3; cfg_scan_en = 4'b1111; cfg_grp_b = 4'b1100;
        cfg_src_a = 2'd1; cfg_src_b = 2'd2;
        exp_q = '{2, 3};
        @(negedge clk); ext_trig = 1'b1;
        tick(40);
        ext_trig = 1'b0;
        chk(starts == 2, "R4", "group B conversions", starts, 2);
        chk(dones_b == 1 && dones_a == 0, "R4", "group B done pulses", dones_b, 1);

        // R5 both groups triggered together
        clear_counts();
        exp_q = '{0, 1, 2, 3};
        @(negedge clk); ext_trig = 1'b1; tmr_trig = 1'b1;
        tick(60);
        ext_trig = 1'b0; tmr_trig = 1'b0;
        chk(starts == 4 && exp_q.size() == 0, "R5", "conversions for both groups", starts, 4);
        chk(dones_a == 1 && dones_b == 1, "R5", "done pulses both groups", dones_a + dones_b, 2);
        chk(done_a_cyc >= 0 && done_a_cyc < done_b_cyc, "R5", "done_a cycle before done_b",
            done_a_cyc, done_b_cyc);
        chk(misses_a == 0 && misses_b == 0, "R7", "no miss for waiting group",
            misses_a + misses_b, 0);

        // R4 group B from software strobe
        clear_counts();
        cfg_src_b = 2'd0;
        exp_q = '{2, 3};
        @(negedge clk); sw_start_b = 1'b1;
        @(negedge clk); sw_start_b = 1'b0;
        tick(40);
        chk(dones_b == 1 && starts == 2, "R4", "group B software start", starts, 2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule